// File: doc/BRIEF.md
# Per-Subcarrier MMSE One-Tap Equalizer

This block scales each frequency-domain sample of a cyclic-prefix block by its own minimum-mean-square-error weight. For subcarrier k the weight is `sig * conj(h_k) / (sig * |h_k|^2 + noise)`. Here `h_k` is the channel response for that subcarrier, and `sig` and `noise` are the signal and noise variances held on configuration inputs. The equalizer is diagonal: every sample is scaled by one complex coefficient, and no sample depends on a neighbouring subcarrier. When the equalizer is disabled, the block passes samples through unchanged at one per cycle.

Each accepted sample arrives with its channel value and an end-of-block marker. The block first forms the conjugate product `y*conj(h)` and the channel power. It then derives a real gain `sig/den` with a sequential non-restoring divider, and finally applies the gain with rounding and saturation. The budget is about three complex multiplies per subcarrier. Only one sample is in flight: the input is held off while the division runs.

The same block serves every cyclic-prefix mode. In the block-despread modes it is simply fed fewer entries per block.

Top module: `subcarrier_mmse_eq`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: With `eq_en` = 0, a sample accepted at a clock edge appears on `out_re`, `out_im` and `out_last` with `out_valid` = 1 after that edge. It appears unchanged, and `in_ready` stays 1, so one sample per cycle passes.
- R3: With `eq_en` = 1, each output component is `sat16(round((z * g) / 2^32))`, where `z = y * conj(h)` (so `z_re = yr*hr + yi*hi` and `z_im = yi*hr - yr*hi`) in full precision.
- R4: The gain is formed in three steps. First `p = floor((hr^2 + hi^2) / 2^14)`. Then `den = sig_var * p + noise_var * 2^14`. Finally `g = min(floor(sig_var * 2^32 / den), 2^32 - 1)`. Channel values are signed with 14 fraction bits, and the variances are unsigned 16-bit.
- R5: When `den` = 0, both output components are 0.
- R6: Rounding is half toward plus infinity: 2^31 is added before an arithmetic shift right by 32. Results are then clamped to the range -32768..32767.
- R7: With `eq_en` = 1, `in_ready` is 0 from the edge that accepts a sample until that sample's result has been presented.
- R8: Outputs leave in acceptance order, and each carries the `in_last` value of its own sample.
- R9: With `eq_en` = 1, each accepted sample yields exactly one single-cycle `out_valid` pulse.
- R10: `sig_var` and `noise_var` are sampled at acceptance. Changes made after that edge do not affect that sample's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eq_en | input | 1 | 1 = equalize, 0 = pass-through |
| sig_var | input | 16 | Signal variance, unsigned |
| noise_var | input | 16 | Noise variance, unsigned, same units as sig_var |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| in_re | input | 16 | Sample real part, signed |
| in_im | input | 16 | Sample imaginary part, signed |
| ch_re | input | 16 | Channel response real part, signed, 14 fraction bits |
| ch_im | input | 16 | Channel response imaginary part, signed, 14 fraction bits |
| in_last | input | 1 | Last sample of the block |
| out_valid | output | 1 | Output sample valid |
| out_re | output | 16 | Equalized real part |
| out_im | output | 16 | Equalized imaginary part |
| out_last | output | 1 | Last-of-block marker of this output |

## Verification
The assertions watch several behaviours on every cycle:
- the input is blocked whenever the divider is busy;
- a pass-through sample appears unchanged one edge later;
- an equalized acceptance produces no output and no ready in the following cycle;
- every quotient the divider returns is bounded by the divisor;
- a zero gain yields a zero result.

The arithmetic itself can only be shown by the directed scenarios. These cover unit and rotated channels, the noise term halving the gain, the zero-denominator case, saturation at both rails, the gain cap, end-of-block marker ordering, and variance changes made after acceptance.

// File: rtl/mmse_eq_pkg.sv
package mmse_eq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DEN,
    ST_DIV,
    ST_MUL
  } eq_state_t;
endpackage

// File: rtl/mmse_eq_prod.sv
// Conjugate product y*conj(h) and scaled channel power.
module mmse_eq_prod #(
  parameter int DW   = 16,
  parameter int FRAC = 14,
  localparam int ZW  = 2*DW+1,
  localparam int PW  = 2*DW+1-FRAC
) (
  input  logic signed [DW-1:0] y_re,
  input  logic signed [DW-1:0] y_im,
  input  logic signed [DW-1:0] c_re,
  input  logic signed [DW-1:0] c_im,
  output logic signed [ZW-1:0] z_re,
  output logic signed [ZW-1:0] z_im,
  output logic        [PW-1:0] pwr
);
  logic signed [2*DW-1:0] rr, ii, ir, ri, sq_r, sq_i;
  logic        [2*DW:0]   psum;

  always_comb begin
    rr   = (2*DW)'(y_re) * (2*DW)'(c_re);
    ii   = (2*DW)'(y_im) * (2*DW)'(c_im);
    ir   = (2*DW)'(y_im) * (2*DW)'(c_re);
    ri   = (2*DW)'(y_re) * (2*DW)'(c_im);
    sq_r = (2*DW)'(c_re) * (2*DW)'(c_re);
    sq_i = (2*DW)'(c_im) * (2*DW)'(c_im);
    z_re = {rr[2*DW-1], rr} + {ii[2*DW-1], ii};
    z_im = {ir[2*DW-1], ir} - {ri[2*DW-1], ri};
    psum = {1'b0, sq_r} + {1'b0, sq_i};
    pwr  = psum[2*DW:FRAC];
  end
endmodule

// File: rtl/mmse_eq_nrdiv.sv
// Sequential non-restoring unsigned divider, one quotient bit per cycle.
module mmse_eq_nrdiv #(
  parameter int NW  = 48,
  parameter int DVW = 36,
  localparam int RW = DVW+2,
  localparam int CW = $clog2(NW),
  localparam int MW = NW+DVW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [NW-1:0]  dividend,
  input  logic [DVW-1:0] divisor,
  output logic           busy,
  output logic           done,
  output logic [NW-1:0]  quot
);
  logic [NW-1:0]        n_q, n_sh;
  logic [DVW-1:0]       d_q;
  logic signed [RW-1:0] rem, sh, rem_n, dext;
  logic [CW-1:0]        cnt;

  always_comb begin
    dext  = {2'b00, d_q};
    sh    = {rem[RW-2:0], n_sh[NW-1]};
    rem_n = rem[RW-1] ? (sh + dext) : (sh - dext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      quot <= '0;
      n_q  <= '0;
      n_sh <= '0;
      d_q  <= '0;
      rem  <= '0;
      cnt  <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        n_q  <= dividend;
        n_sh <= dividend;
        d_q  <= divisor;
        rem  <= '0;
        quot <= '0;
        cnt  <= '0;
        busy <= 1'b1;
      end else if (busy) begin
        rem  <= rem_n;
        quot <= {quot[NW-2:0], ~rem_n[RW-1]};
        n_sh <= n_sh << 1;
        cnt  <= cnt + 1'b1;
        if (cnt == CW'(NW-1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  logic [MW-1:0] qd, nx, dx;
  always_comb begin
    qd = MW'(quot) * MW'(d_q);
    nx = MW'(n_q);
    dx = MW'(d_q);
  end

  // R4: divider starts and yields a correctly bounded quotient
  a_r4_start_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
  a_r4_quotient_bounds: assert property (@(posedge clk) disable iff (rst)
    done |-> ((qd <= nx) && ((nx - qd) < dx)));
endmodule

// File: rtl/mmse_eq_rsat.sv
// Real gain times complex component, round half up, saturate.
module mmse_eq_rsat #(
  parameter int DW  = 16,
  parameter int ZW  = 33,
  parameter int GW  = 32,
  localparam int XW = ZW+GW+1,
  localparam int QW = XW-GW
) (
  input  logic signed [ZW-1:0] z,
  input  logic        [GW-1:0] g,
  output logic signed [DW-1:0] res
);
  logic signed [XW-1:0] prod, rnd;
  logic signed [QW-1:0] q;
  logic                 in_range;

  always_comb begin
    prod     = XW'(z) * $signed({{(XW-GW){1'b0}}, g});
    rnd      = prod + $signed({{(XW-GW){1'b0}}, 1'b1, {(GW-1){1'b0}}});
    q        = rnd[XW-1:GW];
    in_range = (q[QW-1:DW-1] == '0) || (q[QW-1:DW-1] == '1);
    if (in_range)
      res = q[DW-1:0];
    else if (q[QW-1])
      res = {1'b1, {(DW-1){1'b0}}};
    else
      res = {1'b0, {(DW-1){1'b1}}};
    // R5: zero gain must give a zero component
    if (g == '0)
      a_r5_zero_gain: assert (res == '0);
  end
endmodule

// File: rtl/subcarrier_mmse_eq.sv
module subcarrier_mmse_eq
  import mmse_eq_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 14,
  parameter int VW   = 16,
  parameter int GW   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          eq_en,
  input  logic [VW-1:0] sig_var,
  input  logic [VW-1:0] noise_var,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_re,
  input  logic [DW-1:0] in_im,
  input  logic [DW-1:0] ch_re,
  input  logic [DW-1:0] ch_im,
  input  logic          in_last,
  output logic          out_valid,
  output logic [DW-1:0] out_re,
  output logic [DW-1:0] out_im,
  output logic          out_last
);
  localparam int ZW   = 2*DW+1;
  localparam int PW   = 2*DW+1-FRAC;
  localparam int DENW = VW+PW+1;
  localparam int NW   = VW+GW;

  eq_state_t              state;
  logic signed [ZW-1:0]   z_re_w, z_im_w;
  logic        [PW-1:0]   pwr_w, p_q;
  logic signed [ZW-1:0]   z_q   [2];
  logic signed [DW-1:0]   eq_res[2];
  logic        [VW-1:0]   sig_q, nv_q;
  logic                   last_q;
  logic        [GW-1:0]   g_q, g_sat;
  logic        [DENW-1:0] den;
  logic                   div_start, div_busy, div_done;
  logic        [NW-1:0]   quot;

  mmse_eq_prod #(.DW(DW), .FRAC(FRAC)) u_prod (
    .y_re(in_re), .y_im(in_im), .c_re(ch_re), .c_im(ch_im),
    .z_re(z_re_w), .z_im(z_im_w), .pwr(pwr_w)
  );

  always_comb begin
    den       = DENW'(sig_q) * DENW'(p_q) + (DENW'(nv_q) << FRAC);
    div_start = (state == ST_DEN) && (den != '0);
    g_sat     = (quot[NW-1:GW] != '0) ? '1 : quot[GW-1:0];
  end

  mmse_eq_nrdiv #(.NW(NW), .DVW(DENW)) u_div (
    .clk(clk), .rst(rst), .start(div_start),
    .dividend({sig_q, {GW{1'b0}}}), .divisor(den),
    .busy(div_busy), .done(div_done), .quot(quot)
  );

  for (genvar k = 0; k < 2; k++) begin : g_lane
    mmse_eq_rsat #(.DW(DW), .ZW(ZW), .GW(GW)) u_rsat (
      .z(z_q[k]), .g(g_q), .res(eq_res[k])
    );
  end

  assign in_ready = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      out_valid <= 1'b0;
      out_re    <= '0;
      out_im    <= '0;
      out_last  <= 1'b0;
      z_q[0]    <= '0;
      z_q[1]    <= '0;
      p_q       <= '0;
      sig_q     <= '0;
      nv_q      <= '0;
      last_q    <= 1'b0;
      g_q       <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: if (in_valid) begin
          if (!eq_en) begin
            out_re    <= in_re;
            out_im    <= in_im;
            out_last  <= in_last;
            out_valid <= 1'b1;
          end else begin
            z_q[0] <= z_re_w;
            z_q[1] <= z_im_w;
            p_q    <= pwr_w;
            sig_q  <= sig_var;
            nv_q   <= noise_var;
            last_q <= in_last;
            state  <= ST_DEN;
          end
        end
        ST_DEN: begin
          if (den == '0) begin
            g_q   <= '0;
            state <= ST_MUL;
          end else begin
            state <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          g_q   <= g_sat;
          state <= ST_MUL;
        end
        default: begin
          out_re    <= eq_res[0];
          out_im    <= eq_res[1];
          out_last  <= last_q;
          out_valid <= 1'b1;
          state     <= ST_IDLE;
        end
      endcase
    end
  end

  // R7: no acceptance while the divider runs
  a_r7_busy_blocks_input: assert property (@(posedge clk) disable iff (rst)
    div_busy |-> !in_ready);
  // R2: pass-through sample appears unchanged one edge later
  a_r2_bypass_passthrough: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !eq_en) |=>
      (out_valid && out_re == $past(in_re) && out_im == $past(in_im)
       && out_last == $past(in_last)));
  // R9: equalized acceptance holds off output and input next cycle
  a_r9_enabled_holdoff: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && eq_en) |=> (!out_valid && !in_ready));
endmodule

// File: tb/test_subcarrier_mmse_eq.sv
module test_subcarrier_mmse_eq;
  logic        clk = 1'b0;
  logic        rst;
  logic        eq_en;
  logic [15:0] sig_var, noise_var;
  logic        in_valid, in_ready, in_last;
  logic signed [15:0] in_re, in_im, ch_re, ch_im;
  logic        out_valid, out_last;
  logic signed [15:0] out_re, out_im;

  int errs   = 0;
  int checks = 0;

  always #10 clk = ~clk;

  subcarrier_mmse_eq i_subcarrier_mmse_eq (
    .clk(clk), .rst(rst), .eq_en(eq_en), .sig_var(sig_var), .noise_var(noise_var),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .ch_re(ch_re), .ch_im(ch_im), .in_last(in_last),
    .out_valid(out_valid), .out_re(out_re), .out_im(out_im), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected component from the R3/R4/R5/R6 equations.
  function automatic int model(input int yr, input int yi, input int hr, input int hi,
                               input int sg, input int nv, input bit im_part);
    longint z, p, den, q;
    logic signed [95:0] pr;
    z   = im_part ? (longint'(yi)*hi*0 + longint'(yi)*hr - longint'(yr)*hi)
                  : (longint'(yr)*hr + longint'(yi)*hi);
    p   = (longint'(hr)*hr + longint'(hi)*hi) >>> 14;
    den = longint'(sg)*p + (longint'(nv) <<< 14);
    if (den == 0) return 0;
    q = (longint'(sg) <<< 32) / den;
    if (q > 64'sd4294967295) q = 64'sd4294967295;
    pr = 96'(z) * 96'(q);
    pr = pr + (96'sd1 <<< 31);
    pr = pr >>> 32;
    if (pr > 96'sd32767) return 32767;
    if (pr < -96'sd32768) return -32768;
    return int'(pr);
  endfunction

  // Send one equalized sample, wait for its result and compare.
  task automatic send_eq(input int yr, input int yi, input int hr, input int hi,
                         input bit last, input string req, input bit chg_var,
                         input bit use_lit, input int lit_re, input int lit_im);
    int er, ei, n;
    er = model(yr, yi, hr, hi, int'(sig_var), int'(noise_var), 1'b0);
    ei = model(yr, yi, hr, hi, int'(sig_var), int'(noise_var), 1'b1);
    if (use_lit) begin er = lit_re; ei = lit_im; end
    n = 0;
    while (!in_ready && n < 300) begin @(negedge clk); n++; end
    in_valid = 1'b1; in_re = 16'(yr); in_im = 16'(yi);
    ch_re = 16'(hr); ch_im = 16'(hi); in_last = last;
    @(negedge clk);
    in_valid = 1'b0;
    if (chg_var) begin sig_var = 16'd7; noise_var = 16'd60000; end
    chk(!in_ready, "R7", "in_ready after accept", int'(in_ready), 0);
    n = 0;
    while (!out_valid && n < 300) begin @(negedge clk); n++; end
    chk(out_valid, req, "out_valid timeout", int'(out_valid), 1);
    if (out_valid) begin
      chk(int'(out_re) == er, req, "out_re", int'(out_re), er);
      chk(int'(out_im) == ei, req, "out_im", int'(out_im), ei);
      chk(out_last == last, "R8", "out_last", int'(out_last), int'(last));
      @(negedge clk);
      chk(!out_valid, "R9", "single pulse", int'(out_valid), 0);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; eq_en = 1'b0; sig_var = '0; noise_var = '0;
    in_valid = 1'b0; in_re = '0; in_im = '0; ch_re = '0; ch_im = '0; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R1", "out_valid after reset", int'(out_valid), 0);
    chk(in_ready, "R1", "in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_bypass;
    int vr[4] = '{100, -32768, 32767, 5};
    int vi[4] = '{-7, 1234, 0, -999};
    eq_en = 1'b0;
    for (int k = 0; k < 4; k++) begin
      in_valid = 1'b1; in_re = 16'(vr[k]); in_im = 16'(vi[k]);
      ch_re = 16'(3000); ch_im = 16'(-3000); in_last = (k == 3);
      @(negedge clk);
      chk(out_valid, "R2", "bypass valid", int'(out_valid), 1);
      chk(int'(out_re) == vr[k], "R2", "bypass re", int'(out_re), vr[k]);
      chk(int'(out_im) == vi[k], "R2", "bypass im", int'(out_im), vi[k]);
      chk(out_last == (k == 3), "R8", "bypass last", int'(out_last), int'(k == 3));
      chk(in_ready, "R2", "bypass ready", int'(in_ready), 1);
    end
    in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R2", "bypass idle", int'(out_valid), 0);
  endtask

  task automatic t_unit_channel;
    eq_en = 1'b1; sig_var = 16'd4096; noise_var = 16'd0;
    send_eq(1234, -567, 16384, 0, 1'b0, "R3", 1'b0, 1'b1, 1234, -567);
    send_eq(100, 200, 0, -16384, 1'b1, "R3", 1'b0, 1'b1, -200, 100);
  endtask

  task automatic t_noise_term;
    eq_en = 1'b1; sig_var = 16'd1000; noise_var = 16'd1000;
    send_eq(1000, -1001, 16384, 0, 1'b0, "R4", 1'b0, 1'b1, 500, -500);
  endtask

  task automatic t_mixed;
    eq_en = 1'b1; sig_var = 16'd2000; noise_var = 16'd300;
    send_eq(3000, -2000, 11585, 11585, 1'b0, "R3", 1'b0, 1'b0, 0, 0);
    sig_var = 16'd500; noise_var = 16'd50;
    send_eq(-15000, 7000, -9000, 4000, 1'b0, "R4", 1'b0, 1'b0, 0, 0);
    sig_var = 16'd65535; noise_var = 16'd0;
    send_eq(100, -3, 128, 0, 1'b1, "R4", 1'b0, 1'b0, 0, 0);
  endtask

  task automatic t_zero_den;
    eq_en = 1'b1; sig_var = 16'd1000; noise_var = 16'd0;
    send_eq(5000, 5000, 0, 0, 1'b0, "R5", 1'b0, 1'b1, 0, 0);
    send_eq(-300, 42, 100, 0, 1'b1, "R5", 1'b0, 1'b1, 0, 0);
  endtask

  task automatic t_saturate;
    eq_en = 1'b1; sig_var = 16'd100; noise_var = 16'd0;
    send_eq(20000, -20000, 4096, 0, 1'b0, "R6", 1'b0, 1'b1, 32767, -32768);
  endtask

  task automatic t_block_order;
    int yr[4] = '{10, -20, 30, -40};
    eq_en = 1'b1; sig_var = 16'd4096; noise_var = 16'd0;
    for (int k = 0; k < 4; k++)
      send_eq(yr[k], k, 16384, 0, (k == 3), "R8", 1'b0, 1'b1, yr[k], k);
  endtask

  task automatic t_capture;
    eq_en = 1'b1; sig_var = 16'd1000; noise_var = 16'd1000;
    send_eq(800, -600, 16384, 0, 1'b0, "R10", 1'b1, 1'b1, 400, -300);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_bypass();
    t_unit_channel();
    t_noise_term();
    t_mixed();
    t_zero_den();
    t_saturate();
    t_block_order();
    t_capture();
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule